// File: doc/BRIEF.md
# Superscalar Decode Stage Controller

This block sits between instruction fetch and register rename in a superscalar pipeline. Each cycle it is offered a group of up to `W` instruction slots. Each slot carries a valid bit, its PC, its successor PC, a predicted-taken hint, a control-transfer marker, a mispredict marker and a count of source registers. The stage forwards the leading run of valid slots to rename one cycle later. Slots with no source operands are marked ready-to-issue as they pass. Real opcode decoding, target arithmetic and renaming happen elsewhere.

Back-pressure from rename, execute or commit does not drop work. The stage parks each arriving group, whole, in a small FIFO of groups (the skid buffer) and holds fetch off. Once the pressure clears, it replays the parked groups oldest first before it takes fresh fetch traffic again. A commit-side squash, or a reorder buffer that is still flushing, discards everything in flight. A control instruction that the decode stage itself finds mispredicted ends its group, empties the skid buffer and sends fetch a squash with the corrected PC.

Internally a five-state controller (idle, running, blocked, unblocking, squashing) sequences these cases. It leaves reset in the idle state, which forwards traffic exactly as running does.

Top module: `decode_stage_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), out_valid, out_ready, ftc_stall, ftc_squash, ftc_mispredict, err_pred and err_skid_ovf are all 0.
- R2: With no stall or squash, the group offered in cycle t appears on the rename outputs after the next edge. out_valid bit i is 1 for every slot i below the first slot whose in_valid bit is 0, and 0 from that slot upward. Slot i's PC is in_pc[32*i +: 32] and appears at out_pc[32*i +: 32].
- R3: out_ready bit i is 1 exactly when slot i passes and its source count in_nsrc[2*i +: 2] is 0.
- R4: A commit squash while running or unblocking passes nothing in that cycle. The stage then stays squashing, and drops fetch groups, for as long as cmt_squash or rob_squashing is high. It also drops the group offered in the cycle where both are first seen low. The group after that passes normally.
- R5: Any of ren_stall, exe_stall or cmt_stall while running parks the offered group in the skid buffer, passes nothing, and raises ftc_stall after that edge.
- R6: While blocked, a group whose slot 0 is valid is parked. A group whose slot 0 is invalid is not parked.
- R7: When the stalls clear while blocked, the next cycle moves to unblocking with ftc_stall still high. Then one parked group per cycle is emitted, oldest first, and fetch inputs are ignored. ftc_stall stays high until the edge that emits the last parked group, after which it is 0 and fetch groups pass again.
- R8: cmt_squash or rob_squashing while blocked discards every parked group, including one offered in the same cycle, and none of them is emitted later.
- R9: A passing slot with both in_is_ctrl and in_mispred set is the last slot emitted from its group. For one cycle after that edge, ftc_squash and ftc_mispredict are 1 and ftc_redirect_pc equals that slot's in_npc. ftc_squash is never high two cycles in a row.
- R10: A passing slot with in_pred_taken set and in_is_ctrl clear sets err_pred, which stays 1 until reset. Such a slot that does not pass leaves err_pred unchanged.
- R11: The skid buffer holds DEPTH groups (default 4). Parking a group when it is full drops that group and sets err_skid_ovf, which stays 1 until reset. The buffer is never read when empty.
- R12: A mispredict found in a group replayed during unblocking squashes as in R9 and discards the remaining parked groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_stall | input | 1 | Stall request from rename |
| exe_stall | input | 1 | Stall request from execute |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer still flushing |
| in_valid | input | W | Per-slot valid from fetch |
| in_pc | input | W*PC_W | Per-slot PC, slot i at [PC_W*i +: PC_W] |
| in_npc | input | W*PC_W | Per-slot successor PC |
| in_pred_taken | input | W | Per-slot predicted-taken hint |
| in_is_ctrl | input | W | Per-slot control-transfer marker |
| in_mispred | input | W | Per-slot target-checked-and-wrong marker |
| in_nsrc | input | W*SRC_W | Per-slot source register count |
| out_valid | output | W | Registered per-slot valid to rename |
| out_pc | output | W*PC_W | Registered per-slot PC to rename |
| out_ready | output | W | Registered per-slot ready-to-issue flag |
| ftc_stall | output | 1 | Hold-off to fetch |
| ftc_squash | output | 1 | Squash pulse to fetch |
| ftc_mispredict | output | 1 | Prediction-wrong pulse to fetch |
| ftc_redirect_pc | output | PC_W | Corrected fetch PC |
| err_pred | output | 1 | Sticky: taken hint on a non-control slot |
| err_skid_ovf | output | 1 | Sticky: skid buffer overflow |

## Verification
Two events that can land on the same edge are probed. The first is a park and a flush: a valid group arrives while blocked in the same cycle that rob_squashing rises. The stage must discard both the new group and the older parked one, so the bench checks that neither PC ever reaches the rename outputs and that the next fresh group is the first one emitted. The second is a replay and a mispredict: the oldest parked group carries a mispredicted branch. The bench checks that the replay cycle shows the truncated group and the redirect pulse together, and that the second parked group never appears and fetch is released.

// File: rtl/dec_pkg.sv
// Package: shared types for the decode stage controller.
// Assumes: nothing beyond the 1800-2017 language.
package dec_pkg;

    // Control states of the decode stage.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } dec_state_e;

endpackage

// File: rtl/dec_skid_fifo.sv
// Module: dec_skid_fifo
// A FIFO of whole instruction groups, used to park fetch traffic while the
// stage is stalled. Flush has priority over push and pop. A push into a full
// FIFO is dropped and sets a sticky overflow flag. A pop of an empty FIFO is
// ignored.
// Assumes: push and pop are never requested in the same cycle.
module dec_skid_fifo #(
    parameter  int DEPTH = 4,
    parameter  int DW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             empty, full, do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store a pushed group.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= nxt_ptr(rd_ptr);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovf <= 1'b0;
        else if (push && full && !flush)  ovf <= 1'b1;
    end

    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/dec_slot_scan.sv
// Module: dec_slot_scan
// Combinational scan of one instruction group. It works out which slots pass
// (the leading run of valid slots, cut after the first mispredicted control
// slot), which passing slots have no source operands, whether a mispredict
// was found and its redirect PC, and whether a passing non-control slot
// carries a taken hint.
// Assumes: the group is flat, with field bit i (or field i) belonging to slot i.
module dec_slot_scan #(
    parameter int W     = 4,
    parameter int PC_W  = 32,
    parameter int SRC_W = 2
) (
    input  logic [W-1:0]       valid,
    input  logic [W-1:0]       pred,
    input  logic [W-1:0]       ctrl,
    input  logic [W-1:0]       mis,
    input  logic [W*SRC_W-1:0] nsrc,
    input  logic [W*PC_W-1:0]  npc,
    output logic [W-1:0]       pass,
    output logic [W-1:0]       ready,
    output logic               mis_hit,
    output logic [PC_W-1:0]    mis_npc,
    output logic               err_hit
);

    // Walk slots upward, stopping at an invalid slot or after a mispredict.
    always_comb begin
        logic live;
        live    = 1'b1;
        pass    = '0;
        mis_hit = 1'b0;
        mis_npc = '0;
        for (int i = 0; i < W; i++) begin
            if (live && valid[i]) begin
                pass[i] = 1'b1;
                if (ctrl[i] && mis[i]) begin
                    mis_hit = 1'b1;
                    mis_npc = npc[i*PC_W +: PC_W];
                    live    = 1'b0;
                end
            end else begin
                live = 1'b0;
            end
        end
    end

    logic [W-1:0] bad_hint;

    // Per-slot ready-to-issue and hint-error terms.
    for (genvar g = 0; g < W; g++) begin : g_slot
        assign ready[g]    = pass[g] && (nsrc[g*SRC_W +: SRC_W] == '0);
        assign bad_hint[g] = pass[g] && pred[g] && !ctrl[g];
    end

    assign err_hit = |bad_hint;

endmodule

// File: rtl/dec_ctrl.sv
// Module: dec_ctrl
// Five-state control for the decode stage. It chooses each cycle whether to
// pass a group, park it, replay from the skid buffer or flush, and it
// computes the next value of the fetch hold-off.
// Assumes: skid_cnt is the current skid buffer occupancy; mis_hit comes from
// the group selected by use_skid.
module dec_ctrl
    import dec_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_any,
    input  logic             csq,
    input  logic             rob_sq,
    input  logic             fe_has,
    input  logic             mis_hit,
    input  logic [CNT_W-1:0] skid_cnt,
    output dec_state_e       st,
    output logic             use_skid,
    output logic             pass_en,
    output logic             push,
    output logic             pop,
    output logic             flush,
    output logic             stall_next
);

    dec_state_e nxt;

    assign use_skid = (st == ST_UNBLK);

    // Next-state and per-cycle action decode.
    always_comb begin
        nxt     = st;
        push    = 1'b0;
        pop     = 1'b0;
        flush   = 1'b0;
        pass_en = 1'b0;
        unique case (st)
            ST_IDLE, ST_RUN: begin
                if (csq) begin
                    nxt   = ST_SQ;
                    flush = 1'b1;
                end else if (stall_any) begin
                    nxt  = ST_BLK;
                    push = 1'b1;
                end else begin
                    pass_en = 1'b1;
                    if (mis_hit) begin
                        nxt   = ST_SQ;
                        flush = 1'b1;
                    end else if (fe_has) begin
                        nxt = ST_RUN;
                    end
                end
            end
            ST_BLK: begin
                push = fe_has;
                if (csq || rob_sq) begin
                    nxt   = ST_SQ;
                    flush = 1'b1;
                    push  = 1'b0;
                end else if (!stall_any) begin
                    nxt = ST_UNBLK;
                end
            end
            ST_UNBLK: begin
                if (csq) begin
                    nxt   = ST_SQ;
                    flush = 1'b1;
                end else if (stall_any) begin
                    nxt  = ST_BLK;
                    push = 1'b1;
                end else begin
                    pass_en = 1'b1;
                    if (mis_hit) begin
                        nxt   = ST_SQ;
                        flush = 1'b1;
                    end else begin
                        pop = 1'b1;
                        nxt = (skid_cnt > CNT_W'(1)) ? ST_UNBLK : ST_RUN;
                    end
                end
            end
            ST_SQ: begin
                flush = 1'b1;
                if (!csq && !rob_sq) nxt = ST_RUN;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign stall_next = (st == ST_BLK) || (nxt == ST_BLK) || (nxt == ST_UNBLK);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    a_r7_unblk_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNBLK) |-> (skid_cnt != '0));

endmodule

// File: rtl/decode_stage_ctrl.sv
// Module: decode_stage_ctrl (top)
// Superscalar decode stage: forwards up to W instruction slots per cycle from
// fetch to rename, parks whole groups in a skid buffer under back-pressure,
// replays them when pressure clears, and squashes on commit request or on a
// mispredict found here. All outputs are registered.
// Assumes: fetch respects ftc_stall. While unblocking, fetch inputs are ignored.
module decode_stage_ctrl
    import dec_pkg::*;
#(
    parameter int W          = 4,
    parameter int PC_W       = 32,
    parameter int SRC_W      = 2,
    parameter int SKID_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ren_stall,
    input  logic               exe_stall,
    input  logic               cmt_stall,
    input  logic               cmt_squash,
    input  logic               rob_squashing,
    input  logic [W-1:0]       in_valid,
    input  logic [W*PC_W-1:0]  in_pc,
    input  logic [W*PC_W-1:0]  in_npc,
    input  logic [W-1:0]       in_pred_taken,
    input  logic [W-1:0]       in_is_ctrl,
    input  logic [W-1:0]       in_mispred,
    input  logic [W*SRC_W-1:0] in_nsrc,
    output logic [W-1:0]       out_valid,
    output logic [W*PC_W-1:0]  out_pc,
    output logic [W-1:0]       out_ready,
    output logic               ftc_stall,
    output logic               ftc_squash,
    output logic               ftc_mispredict,
    output logic [PC_W-1:0]    ftc_redirect_pc,
    output logic               err_pred,
    output logic               err_skid_ovf
);

    localparam int O_V   = 0;
    localparam int O_P   = W;
    localparam int O_C   = 2 * W;
    localparam int O_M   = 3 * W;
    localparam int O_N   = 4 * W;
    localparam int O_PC  = O_N + W * SRC_W;
    localparam int O_NPC = O_PC + W * PC_W;
    localparam int GW    = O_NPC + W * PC_W;
    localparam int CNT_W = $clog2(SKID_DEPTH + 1);

    logic [GW-1:0]    fetch_grp, skid_grp, src_grp;
    logic [CNT_W-1:0] skid_cnt;
    dec_state_e       st;
    logic             use_skid, pass_en, push, pop, flush, stall_next;
    logic [W-1:0]     pass, ready;
    logic             mis_hit, err_hit;
    logic [PC_W-1:0]  mis_npc;

    assign fetch_grp = {in_npc, in_pc, in_nsrc, in_mispred, in_is_ctrl, in_pred_taken, in_valid};
    assign src_grp   = use_skid ? skid_grp : fetch_grp;

    dec_skid_fifo #(.DEPTH(SKID_DEPTH), .DW(GW)) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .din   (fetch_grp),
        .dout  (skid_grp),
        .cnt   (skid_cnt),
        .ovf   (err_skid_ovf)
    );

    dec_slot_scan #(.W(W), .PC_W(PC_W), .SRC_W(SRC_W)) u_scan (
        .valid   (src_grp[O_V +: W]),
        .pred    (src_grp[O_P +: W]),
        .ctrl    (src_grp[O_C +: W]),
        .mis     (src_grp[O_M +: W]),
        .nsrc    (src_grp[O_N +: W*SRC_W]),
        .npc     (src_grp[O_NPC +: W*PC_W]),
        .pass    (pass),
        .ready   (ready),
        .mis_hit (mis_hit),
        .mis_npc (mis_npc),
        .err_hit (err_hit)
    );

    dec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_any  (ren_stall || exe_stall || cmt_stall),
        .csq        (cmt_squash),
        .rob_sq     (rob_squashing),
        .fe_has     (in_valid[0]),
        .mis_hit    (mis_hit),
        .skid_cnt   (skid_cnt),
        .st         (st),
        .use_skid   (use_skid),
        .pass_en    (pass_en),
        .push       (push),
        .pop        (pop),
        .flush      (flush),
        .stall_next (stall_next)
    );

    // Rename-side output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_ready <= '0;
            out_pc    <= '0;
        end else begin
            out_valid <= pass_en ? pass  : '0;
            out_ready <= pass_en ? ready : '0;
            out_pc    <= src_grp[O_PC +: W*PC_W];
        end
    end

    // Fetch-side control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftc_stall       <= 1'b0;
            ftc_squash      <= 1'b0;
            ftc_mispredict  <= 1'b0;
            ftc_redirect_pc <= '0;
        end else begin
            ftc_stall      <= stall_next;
            ftc_squash     <= pass_en && mis_hit;
            ftc_mispredict <= pass_en && mis_hit;
            if (pass_en && mis_hit) ftc_redirect_pc <= mis_npc;
        end
    end

    // Sticky taken-hint error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_pred <= 1'b0;
        else if (pass_en && err_hit) err_pred <= 1'b1;
    end

    a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + W'(1))) == '0));
    a_r4_no_pass_on_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_squash && (st == ST_RUN || st == ST_IDLE || st == ST_UNBLK)) |=> (out_valid == '0));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ftc_squash |=> !ftc_squash);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_pred |=> err_pred);

endmodule

// File: tb/sim_decode_stage_ctrl.sv
module sim_decode_stage_ctrl;

    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ren_stall, exe_stall, cmt_stall, cmt_squash, rob_squashing;
    logic [W-1:0]  in_valid, in_pred_taken, in_is_ctrl, in_mispred;
    logic [127:0]  in_pc, in_npc;
    logic [7:0]    in_nsrc;
    logic [W-1:0]  out_valid, out_ready;
    logic [127:0]  out_pc;
    logic          ftc_stall, ftc_squash, ftc_mispredict, err_pred, err_skid_ovf;
    logic [31:0]   ftc_redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    decode_stage_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ren_stall(ren_stall), .exe_stall(exe_stall),
        .cmt_stall(cmt_stall), .cmt_squash(cmt_squash), .rob_squashing(rob_squashing),
        .in_valid(in_valid), .in_pc(in_pc), .in_npc(in_npc), .in_pred_taken(in_pred_taken),
        .in_is_ctrl(in_is_ctrl), .in_mispred(in_mispred), .in_nsrc(in_nsrc),
        .out_valid(out_valid), .out_pc(out_pc), .out_ready(out_ready),
        .ftc_stall(ftc_stall), .ftc_squash(ftc_squash), .ftc_mispredict(ftc_mispredict),
        .ftc_redirect_pc(ftc_redirect_pc), .err_pred(err_pred), .err_skid_ovf(err_skid_ovf)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_in();
        in_valid = '0; in_pred_taken = '0; in_is_ctrl = '0; in_mispred = '0;
        in_pc = '0; in_npc = '0; in_nsrc = '0;
    endtask

    task automatic clr_flags();
        ren_stall = 0; exe_stall = 0; cmt_stall = 0; cmt_squash = 0; rob_squashing = 0;
    endtask

    task automatic set_slot(input int i, input logic [31:0] pc, input logic [1:0] ns);
        in_valid[i]        = 1'b1;
        in_pc[i*32 +: 32]  = pc;
        in_npc[i*32 +: 32] = pc + 32'd4;
        in_nsrc[i*2 +: 2]  = ns;
    endtask

    task automatic fill(input logic [31:0] base, input int n);
        clr_in();
        for (int i = 0; i < n; i++) set_slot(i, base + 32'(4 * i), 2'd1);
    endtask

    task automatic t_reset();
        rst_n = 0; clr_flags(); clr_in();
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1", "out_valid", 64'(out_valid), 0);
        chk("R1", "out_ready", 64'(out_ready), 0);
        chk("R1", "stall/squash/mispredict", {ftc_stall, ftc_squash, ftc_mispredict}, 0);
        chk("R1", "error flags", {err_pred, err_skid_ovf}, 0);
    endtask

    task automatic t_pass();
        fill(32'h100, 4);
        in_nsrc = {2'd0, 2'd2, 2'd1, 2'd0};
        tick();
        chk("R2", "full group valid", 64'(out_valid), 64'hF);
        chk("R2", "slot2 pc", 64'(out_pc[64 +: 32]), 64'h108);
        chk("R3", "ready mask", 64'(out_ready), 64'h9);
        fill(32'h180, 4);
        in_valid[2] = 1'b0;
        in_pred_taken[3] = 1'b1;
        tick();
        chk("R2", "stop at first invalid", 64'(out_valid), 64'h3);
        chk("R10", "hint on dropped slot ignored", 64'(err_pred), 0);
        clr_in();
        tick();
        chk("R2", "empty group", 64'(out_valid), 0);
    endtask

    task automatic t_commit_squash();
        fill(32'h200, 4); cmt_squash = 1;
        tick();
        chk("R4", "no pass on squash", 64'(out_valid), 0);
        tick();
        chk("R4", "held squash", 64'(out_valid), 0);
        cmt_squash = 0; rob_squashing = 1;
        tick();
        chk("R4", "rob squashing holds", 64'(out_valid), 0);
        rob_squashing = 0;
        tick();
        chk("R4", "exit cycle drops group", 64'(out_valid), 0);
        fill(32'h240, 4);
        tick();
        chk("R4", "resume", 64'(out_valid), 64'hF);
        chk("R4", "resume pc", 64'(out_pc[31:0]), 64'h240);
    endtask

    task automatic t_stall_unblock();
        fill(32'h300, 4); ren_stall = 1;
        tick();
        chk("R5", "nothing passes", 64'(out_valid), 0);
        chk("R5", "stall raised", 64'(ftc_stall), 1);
        fill(32'h400, 2); ren_stall = 0; exe_stall = 1;
        tick();
        chk("R6", "stall held", 64'(ftc_stall), 1);
        clr_in(); exe_stall = 0; cmt_stall = 1;
        tick();
        cmt_stall = 0;
        tick();
        chk("R7", "to unblock, stall held", 64'(ftc_stall), 1);
        chk("R7", "nothing yet", 64'(out_valid), 0);
        fill(32'hDEAD0, 4);
        tick();
        chk("R7", "oldest first valid", 64'(out_valid), 64'hF);
        chk("R7", "oldest first pc", 64'(out_pc[31:0]), 64'h300);
        chk("R7", "stall while entries remain", 64'(ftc_stall), 1);
        tick();
        chk("R7", "second group valid", 64'(out_valid), 64'h3);
        chk("R7", "second group pc", 64'(out_pc[31:0]), 64'h400);
        chk("R6", "empty group not parked, stall released", 64'(ftc_stall), 0);
        fill(32'h500, 1);
        tick();
        chk("R7", "fetch passes again", 64'(out_valid), 64'h1);
        chk("R7", "fetch pc", 64'(out_pc[31:0]), 64'h500);
    endtask

    task automatic t_squash_blocked();
        fill(32'h600, 4); ren_stall = 1;
        tick();
        fill(32'h640, 4); rob_squashing = 1;
        tick();
        chk("R8", "nothing passes", 64'(out_valid), 0);
        ren_stall = 0; rob_squashing = 0; fill(32'h680, 4);
        tick();
        chk("R8", "exit cycle drops group", 64'(out_valid), 0);
        chk("R8", "fetch released", 64'(ftc_stall), 0);
        fill(32'h6C0, 2);
        tick();
        chk("R8", "parked groups discarded", 64'(out_pc[31:0]), 64'h6C0);
        chk("R8", "fresh group valid", 64'(out_valid), 64'h3);
    endtask

    task automatic t_mispredict();
        fill(32'h700, 4);
        in_is_ctrl[1] = 1; in_mispred[1] = 1; in_npc[63:32] = 32'h5550;
        tick();
        chk("R9", "group cut after branch", 64'(out_valid), 64'h3);
        chk("R9", "squash pulse", {ftc_squash, ftc_mispredict}, 64'h3);
        chk("R9", "redirect pc", 64'(ftc_redirect_pc), 64'h5550);
        fill(32'h740, 4);
        tick();
        chk("R9", "pulse ends", 64'(ftc_squash), 0);
        chk("R9", "following group dropped", 64'(out_valid), 0);
        fill(32'h780, 4);
        in_is_ctrl[0] = 1; in_mispred[0] = 1; in_npc[31:0] = 32'h6660;
        tick();
        chk("R9", "slot0 branch alone", 64'(out_valid), 64'h1);
        chk("R9", "redirect slot0", 64'(ftc_redirect_pc), 64'h6660);
        clr_in();
        tick();
    endtask

    task automatic t_pred_err();
        fill(32'h800, 1); in_pred_taken[0] = 1;
        tick();
        chk("R10", "bad hint passes", 64'(out_valid), 64'h1);
        chk("R10", "err set", 64'(err_pred), 1);
        fill(32'h840, 1);
        tick();
        chk("R10", "err sticky", 64'(err_pred), 1);
    endtask

    task automatic t_unblock_mispredict();
        fill(32'hA00, 2); in_is_ctrl[0] = 1; in_mispred[0] = 1; in_npc[31:0] = 32'h7770;
        exe_stall = 1;
        tick();
        fill(32'hA40, 4);
        tick();
        clr_in(); exe_stall = 0;
        tick();
        chk("R12", "unblocking stall", 64'(ftc_stall), 1);
        tick();
        chk("R12", "replayed branch only", 64'(out_valid), 64'h1);
        chk("R12", "replayed pc", 64'(out_pc[31:0]), 64'hA00);
        chk("R12", "redirect", 64'(ftc_redirect_pc), 64'h7770);
        chk("R12", "squash pulse", 64'(ftc_squash), 1);
        chk("R12", "fetch released", 64'(ftc_stall), 0);
        fill(32'hA80, 4);
        tick();
        chk("R12", "second parked group gone", 64'(out_valid), 0);
        fill(32'hAC0, 3);
        tick();
        chk("R12", "fresh pc", 64'(out_pc[31:0]), 64'hAC0);
        chk("R12", "fresh valid", 64'(out_valid), 64'h7);
    endtask

    task automatic t_overflow();
        cmt_stall = 1;
        for (int k = 0; k < 4; k++) begin
            fill(32'h900 + 32'(16 * k), 1);
            tick();
        end
        chk("R11", "no overflow at depth", 64'(err_skid_ovf), 0);
        fill(32'h940, 1);
        tick();
        chk("R11", "overflow flagged", 64'(err_skid_ovf), 1);
        clr_in(); cmt_stall = 0;
        tick();
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R11", "drain pc", 64'(out_pc[31:0]), 64'(32'h900 + 32'(16 * k)));
            chk("R11", "drain valid", 64'(out_valid), 64'h1);
        end
        chk("R11", "stall released after drain", 64'(ftc_stall), 0);
        tick();
        chk("R11", "dropped group absent", 64'(out_valid), 0);
        chk("R11", "overflow sticky", 64'(err_skid_ovf), 1);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_commit_squash();
        t_stall_unblock();
        t_squash_blocked();
        t_mispredict();
        t_pred_err();
        t_unblock_mispredict();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule